// File: doc/BRIEF.md
# Forwarding-Table Register Window

This block keeps a table of 68-bit forwarding entries. Software has no direct path to it. All access goes through a small register window on a simple write/read bus.

To change an entry, software fills three 32-bit staging words and then writes an index together with a command bit to a table command register. When the command bit is set, the staged value is committed to the indexed entry. When it is clear, the indexed entry is fetched back into the staging words. A global control register holds an enable bit, an ageing-request bit and a clear bit. Setting the clear bit starts a hardware sweep that marks every entry free. An identity register reports the revision.

Reads are combinational on the bus address. Writes take effect at the rising clock edge at which `bus_wr` is high.

Top module: `tbl_window`

## Requirements
- R1: After reset, offset 0x00 reads `{16'h0, VER_MAJOR, VER_MINOR}`, with the major revision in bits 15:8 and the minor revision in bits 7:0. It ignores writes. The global control register and all staging words read 0.
- R2: Staging words sit at offsets 0x34 (word 0), 0x38 (word 1) and 0x3C (word 2). Each reads back what was last written, except that word 0 keeps only bits 3:0 and reads 0 in bits 31:4.
- R3: A write to offset 0x20 with bit 31 set and a valid index in bits 15:0 stores the entry {word0[3:0], word1, word2}. Entry bits 67:64 come from word 0, bits 63:32 from word 1 and bits 31:0 from word 2.
- R4: A write to offset 0x20 with bit 31 clear and a valid index fetches that entry into the staging words at the next clock edge. Bit 30 of offset 0x20 reads 1 for exactly that one cycle and reads 0 otherwise.
- R5: A command whose index is at or above `N_ENTRIES` is ignored. The staging words stay unchanged and no entry is written; in particular, no entry is written through a truncated index.
- R6: Writing 1 to bit 30 of offset 0x08 starts a sweep that writes entry type 0 (bits 61:60, where 0 means free) into each entry, one entry per cycle. All other entry bits are kept. Bit 30 reads 1 for exactly `N_ENTRIES` cycles after the write, and 0 afterwards.
- R7: Bits 31 (enable) and 29 (ageing request) of offset 0x08 are plain read/write storage. All other bits of that register read 0, apart from bit 30 as described in R6.
- R8: Table commands written while a sweep is running are ignored.
- R9: Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
A wrong internal state shows up at the ports in one of three ways:
- A stuck fetch flag shows as bit 30 of the command register staying high past its single cycle.
- A sweep pointer that stops early or runs long changes the number of cycles for which bit 30 of the control register reads high. That count is visible within `N_ENTRIES`+1 cycles.
- Table corruption stays hidden until the affected entry is fetched. The bench therefore fetches entries after every commit, every out-of-range command and every sweep. It compares all three staging words, so a field placed in the wrong word or position shows up one cycle after the fetch.

// File: rtl/tbl_window.sv
module tbl_window #(
  parameter int N_ENTRIES = 64,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int IW = $clog2(N_ENTRIES);
  localparam int EW = 68;
  localparam logic [IW-1:0] LAST = IW'(N_ENTRIES - 1);
  localparam logic [7:0] A_VER = 8'h00, A_GCTL = 8'h08, A_TCMD = 8'h20;
  localparam logic [7:0] A_W0 = 8'h34, A_W1 = 8'h38, A_W2 = 8'h3C;

  logic [EW-1:0] tbl [N_ENTRIES];
  logic [3:0]    stg0;
  logic [31:0]   stg1, stg2;
  logic          en_q, age_q, clr_act, rd_pend;
  logic [IW-1:0] clr_ptr, rd_idx;
  logic [29:0]   tcmd_q;

  wire tcmd_hit = bus_wr && bus_addr == A_TCMD && !clr_act;
  wire idx_ok   = 32'(bus_wdata[15:0]) < N_ENTRIES;
  wire do_put   = tcmd_hit && idx_ok && bus_wdata[31];
  wire do_get   = tcmd_hit && idx_ok && !bus_wdata[31];
  wire [IW-1:0] cmd_idx = bus_wdata[IW-1:0];
  wire gctl_wr  = bus_wr && bus_addr == A_GCTL;

  always_ff @(posedge clk) begin
    if (do_put) tbl[cmd_idx] <= {stg0, stg1, stg2};
    else if (clr_act) tbl[clr_ptr][61:60] <= 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg0 <= '0;
      stg1 <= '0;
      stg2 <= '0;
    end else if (rd_pend) begin
      {stg0, stg1, stg2} <= tbl[rd_idx];
    end else if (bus_wr) begin
      if (bus_addr == A_W0) stg0 <= bus_wdata[3:0];
      if (bus_addr == A_W1) stg1 <= bus_wdata;
      if (bus_addr == A_W2) stg2 <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      age_q   <= 1'b0;
      clr_act <= 1'b0;
      clr_ptr <= '0;
    end else begin
      if (gctl_wr) begin
        en_q  <= bus_wdata[31];
        age_q <= bus_wdata[29];
      end
      if (clr_act) begin
        if (clr_ptr == LAST) clr_act <= 1'b0;
        else clr_ptr <= clr_ptr + 1'b1;
      end else if (gctl_wr && bus_wdata[30]) begin
        clr_act <= 1'b1;
        clr_ptr <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_idx  <= '0;
      tcmd_q  <= '0;
    end else begin
      rd_pend <= do_get;
      if (do_get) rd_idx <= cmd_idx;
      if (do_put || do_get) tcmd_q <= bus_wdata[29:0];
    end
  end

  always_comb begin
    case (bus_addr)
      A_VER:   bus_rdata = {16'h0, VER_MAJOR, VER_MINOR};
      A_GCTL:  bus_rdata = {en_q, clr_act, age_q, 29'h0};
      A_TCMD:  bus_rdata = {1'b0, rd_pend, tcmd_q};
      A_W0:    bus_rdata = {28'h0, stg0};
      A_W1:    bus_rdata = stg1;
      A_W2:    bus_rdata = stg2;
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/tbl_window_chk.sv
module tbl_window_chk #(
  parameter int N_ENTRIES = 64,
  parameter logic [7:0] VER_MAJOR = 8'h01,
  parameter logic [7:0] VER_MINOR = 8'h04
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        rd_pend,
  input logic        clr_act,
  input logic [$clog2(N_ENTRIES)-1:0] clr_ptr
);
  localparam int IW = $clog2(N_ENTRIES);
  localparam logic [IW-1:0] LAST = IW'(N_ENTRIES - 1);

  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 8'h00 |-> bus_rdata == {16'h0, VER_MAJOR, VER_MINOR});

  assert_fetch_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> !rd_pend);

  assert_sweep_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act && clr_ptr != LAST |=> clr_act && clr_ptr == $past(clr_ptr) + 1'b1);

  assert_sweep_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act && clr_ptr == LAST |=> !clr_act);

  assert_no_fetch_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |-> !rd_pend);

  assert_gctl_bit30_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 8'h08 |-> bus_rdata[30] == clr_act);
endmodule

bind tbl_window tbl_window_chk #(
  .N_ENTRIES(N_ENTRIES), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_pend(rd_pend),
  .clr_act(clr_act), .clr_ptr(clr_ptr)
);

// File: tb/tbl_window_bench.sv
module tbl_window_bench;
  localparam int N = 64;
  localparam logic [31:0] VER = 32'h0000_0104;
  localparam logic [7:0] VERA = 8'h00, GCTL = 8'h08, TCMD = 8'h20;
  localparam logic [7:0] W0 = 8'h34, W1 = 8'h38, W2 = 8'h3C;
  localparam int NV = 9;
  localparam logic [79:0] VEC [NV] = '{
    {W0,   32'hFFFF_FFFF, W0,   32'h0000_000F},
    {W1,   32'h1234_5678, W1,   32'h1234_5678},
    {W2,   32'hDEAD_BEEF, W2,   32'hDEAD_BEEF},
    {W0,   32'h0000_0005, W0,   32'h0000_0005},
    {GCTL, 32'hA000_0000, GCTL, 32'hA000_0000},
    {GCTL, 32'h0000_0000, GCTL, 32'h0000_0000},
    {8'h44,32'hFFFF_FFFF, 8'h44,32'h0000_0000},
    {8'h04,32'h5555_5555, 8'h04,32'h0000_0000},
    {VERA, 32'hFFFF_FFFF, VERA, VER}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbl_window #(.N_ENTRIES(N)) u_tbl_window (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic put(input int idx, input logic [3:0] a, input logic [31:0] b, input logic [31:0] c);
    wr(W0, {28'h0, a}); wr(W1, b); wr(W2, c);
    wr(TCMD, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic fetch_chk(input string req, input int idx, input logic [3:0] a,
                           input logic [31:0] b, input logic [31:0] c);
    logic [31:0] v;
    wr(TCMD, 32'(idx));
    rd(TCMD, v);
    chk("R4", "busy during fetch", {31'h0, v[30]}, 32'h1);
    @(negedge clk);
    rd(TCMD, v);
    chk("R4", "busy after fetch", {31'h0, v[30]}, 32'h0);
    rd(W0, v); chk(req, "word0", v, {28'h0, a});
    rd(W1, v); chk(req, "word1", v, b);
    rd(W2, v); chk(req, "word2", v, c);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    #23 rst_n = 1'b1;
    // R1 reset state
    rd(VERA, v); chk("R1", "version", v, VER);
    rd(GCTL, v); chk("R1", "gctl reset", v, 32'h0);
    rd(W0, v);   chk("R1", "word0 reset", v, 32'h0);
    rd(W1, v);   chk("R1", "word1 reset", v, 32'h0);
    rd(W2, v);   chk("R1", "word2 reset", v, 32'h0);

    // R2 R7 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], v);
      chk("R2/R7/R9", $sformatf("vector %0d", i), v, VEC[i][31:0]);
    end

    // R6 initial sweep, cycle count
    wr(GCTL, 32'h4000_0000);
    cnt = 0;
    rd(GCTL, v);
    while (v[30] && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      rd(GCTL, v);
    end
    chk("R6", "sweep cycles", 32'(cnt), 32'(N));

    // R3 R4 commit then fetch
    put(5, 4'hA, 32'h3123_4567, 32'h89AB_CDEF);
    put(N - 1, 4'h6, 32'h1FED_CBA9, 32'h0BAD_F00D);
    wr(W0, 0); wr(W1, 0); wr(W2, 0);
    fetch_chk("R3", 5, 4'hA, 32'h3123_4567, 32'h89AB_CDEF);
    fetch_chk("R3", N - 1, 4'h6, 32'h1FED_CBA9, 32'h0BAD_F00D);

    // R5 out of range fetch leaves staging alone
    put(0, 4'h1, 32'h1111_1111, 32'h2222_2222);
    wr(W0, 32'h3); wr(W1, 32'h4444_4444); wr(W2, 32'h5555_5555);
    wr(TCMD, 32'(N));
    @(negedge clk);
    rd(TCMD, v); chk("R5", "no busy on bad index", {31'h0, v[30]}, 32'h0);
    rd(W1, v); chk("R5", "word1 kept", v, 32'h4444_4444);
    rd(W2, v); chk("R5", "word2 kept", v, 32'h5555_5555);
    // R5 out of range commit does not alias entry 0
    wr(TCMD, 32'h8000_0000 | 32'(N));
    fetch_chk("R5", 0, 4'h1, 32'h1111_1111, 32'h2222_2222);

    // R6 R7 R8 sweep keeps other bits, commands ignored meanwhile
    wr(GCTL, 32'hC000_0000);
    rd(GCTL, v); chk("R7", "gctl during sweep", v, 32'hC000_0000);
    wr(W1, 32'h2000_0000); wr(W2, 32'h0);
    wr(TCMD, 32'h8000_0005);
    wr(TCMD, 32'h0000_0000);
    rd(TCMD, v); chk("R8", "no fetch in sweep", {31'h0, v[30]}, 32'h0);
    rd(W1, v); chk("R8", "staging untouched", v, 32'h2000_0000);
    cnt = 0;
    rd(GCTL, v);
    while (v[30] && cnt < 1000) begin
      cnt++;
      @(negedge clk);
      rd(GCTL, v);
    end
    rd(GCTL, v); chk("R7", "gctl after sweep", v, 32'h8000_0000);
    fetch_chk("R6", 5, 4'hA, 32'h0123_4567, 32'h89AB_CDEF);
    fetch_chk("R6", N - 1, 4'h6, 32'h0FED_CBA9, 32'h0BAD_F00D);

    // R1 reset again restores defaults
    rst_n = 1'b0; #7; rst_n = 1'b1;
    rd(GCTL, v); chk("R1", "gctl after reset", v, 32'h0);
    rd(W2, v);   chk("R1", "word2 after reset", v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule